// File: doc/BRIEF.md
# Configurable GPIO Port Controller

A general-purpose I/O controller for a microcontroller subsystem. It serves three ports: ports 0 and 1 have eight pins each and port 2 has five pins (bits 0 to 4). Software reaches it through a simple register bus with a combinational read path, a single-cycle write strobe and a read-modify-write strobe. For each pin it sets the pad output enable, the pad output value and the pad pull-up enable. It passes peripheral output signals through to the pads when a pin is assigned to a peripheral.

Pin inputs pass through a two-flop synchronizer. The synchronized levels feed the data read path and a per-pin edge detector. Each port has a pending register, a mask register and an edge-select bit. Each port has its own interrupt line, and a wake output combines all three lines. A hold input freezes the pad drive state so that the pads keep their value across a power-mode change.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, the direction, function-select, input-mode, mask, edge-select and pending registers of every port read 0. `pad_oe_o` is all 0 and `irq_o` is 0. `pad_pull_en_o` equals 24'h1FFCFF, so every pin that has a pull resistor has its pull-up enabled.
- R2: Port 2 has only bits 0 to 4. Its bits 5 to 7 read back as 0 from every register and ignore writes. The pad outputs of those bits (`pad_*_o[23:21]`) stay 0.
- R3: Bus address bits [4:3] select the port and bits [2:0] select the register: 0 data, 1 direction, 2 function select, 3 input mode, 4 interrupt mask, 5 edge select (bit 0 only), 6 pending. On a general-purpose pin (function select 0) with direction 1, `pad_oe_o` is 1 and `pad_out_o` equals the data latch bit.
- R4: A data read without `bus_rmw_i` returns the pin level sampled through two flops. A pin change driven before clock edge k is visible after edge k+1. This holds whatever the direction or function setting of the pin.
- R5: A data read with `bus_rmw_i` high returns the data latch instead of the pin level.
- R6: On a pin with function select 1, `pad_out_o` and `pad_oe_o` come from `periph_out_i` and `periph_oe_i`. The data latch keeps its value, and a read-modify-write read still returns it.
- R7: `pad_pull_en_o` is 1 only on a pin that has a pull resistor, is not driven, and has input mode 0. Input mode 1 turns the pull off. Port 1 pins 0 and 1 never pull.
- R8: While `hold_i` is high, `pad_oe_o` and `pad_out_o` keep the values they had in the cycle before hold rose. Register writes made during hold still update the registers, and the pads follow those registers once hold falls.
- R9: A pending bit sets on a rising edge of the synchronized pin when the port's edge select is 0, and on a falling edge when it is 1. A pin change driven before edge k sets the pending bit at edge k+2. An edge of the other polarity sets nothing.
- R10: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. If a new edge and a clear arrive in the same cycle, the bit stays set.
- R11: `irq_o[p]` is the OR of port p's pending bits ANDed with its mask bits. `wake_o` is the OR of `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 5 | Port (bits 4:3) and register (bits 2:0) select |
| bus_we_i | input | 1 | Write strobe |
| bus_rmw_i | input | 1 | Read-modify-write access: data reads return the latch |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (combinational) |
| hold_i | input | 1 | Freeze pad drive state |
| pad_in_i | input | 24 | Pad input levels, 8 bits per port |
| periph_out_i | input | 24 | Peripheral output values |
| periph_oe_i | input | 24 | Peripheral output enables |
| pad_out_o | output | 24 | Pad output values |
| pad_oe_o | output | 24 | Pad output enables |
| pad_pull_en_o | output | 24 | Pad pull-up enables |
| irq_o | output | 3 | Per-port interrupt |
| wake_o | output | 1 | Wake-up request |

## Verification
A pin edge reaching the pending register and a software write-1 clear of the same bit can land on the same clock edge. The bench provokes this by driving the pin, counting two clock edges through the synchronizer, and then timing the clear write onto the third edge. It judges the result as correct only if the bit is still pending afterwards. A control case, where the clear is issued with no edge present, confirms that the clear on its own empties the bit.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int NPORT  = 3;
  localparam int PW     = 8;
  localparam int PSEL_W = 2;
  localparam int RSEL_W = 3;
  localparam int AW     = PSEL_W + RSEL_W;
  localparam int NPIN   = NPORT * PW;

  typedef enum logic [RSEL_W-1:0] {
    REG_DATA   = 3'd0,
    REG_DIR    = 3'd1,
    REG_SEL    = 3'd2,
    REG_INMODE = 3'd3,
    REG_MASK   = 3'd4,
    REG_EDGE   = 3'd5,
    REG_PEND   = 3'd6
  } reg_e;

  function automatic logic [PW-1:0] used_mask(int p);
    return (p == 2) ? 8'h1F : 8'hFF;
  endfunction

  function automatic logic [PW-1:0] pull_mask(int p);
    return (p == 1) ? (used_mask(p) & 8'hFC) : used_mask(p);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int          W    = 8,
  parameter logic [W-1:0] USED = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic         fall_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o,
  output logic         irq_o
);
  logic [W-1:0] prev_q, pend_q, evt;

  always_comb begin
    if (fall_i) evt = prev_q & ~lvl_i & USED;
    else        evt = ~prev_q & lvl_i & USED;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= lvl_i;
      // a new edge wins over a same-cycle clear
      pend_q <= (pend_q & ~clr_i) | evt;
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & mask_i);

  // R9
  pend_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(evt)) == '0));

  // R10
  pend_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(pend_q) & ~pend_q & ~$past(clr_i)) == '0));

  // R11
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(|evt) || !$stable(mask_i)));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int           W        = 8,
  parameter logic [W-1:0] USED     = '1,
  parameter logic [W-1:0] PULLABLE = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  reg_e         reg_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rmw_i,
  output logic [W-1:0] rdata_o,
  input  logic         hold_i,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] periph_out_i,
  input  logic [W-1:0] periph_oe_i,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pad_oe_o,
  output logic [W-1:0] pull_en_o,
  output logic         irq_o
);
  logic [W-1:0] data_q, dir_q, sel_q, inmode_q, mask_q;
  logic         fall_q;
  logic [W-1:0] pin_s, pend, clr;
  logic [W-1:0] eff_out, eff_oe, snap_out_q, snap_oe_q;

  gpio_sync #(.W(W)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q   <= '0;
      dir_q    <= '0;
      sel_q    <= '0;
      inmode_q <= '0;
      mask_q   <= '0;
      fall_q   <= 1'b0;
    end else if (we_i) begin
      case (reg_i)
        REG_DATA:   data_q   <= wdata_i & USED;
        REG_DIR:    dir_q    <= wdata_i & USED;
        REG_SEL:    sel_q    <= wdata_i & USED;
        REG_INMODE: inmode_q <= wdata_i & USED;
        REG_MASK:   mask_q   <= wdata_i & USED;
        REG_EDGE:   fall_q   <= wdata_i[0];
        default: ;
      endcase
    end
  end

  assign clr = (we_i && reg_i == REG_PEND) ? (wdata_i & USED) : '0;

  gpio_irq #(.W(W), .USED(USED)) i_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (pin_s),
    .fall_i(fall_q),
    .mask_i(mask_q),
    .clr_i (clr),
    .pend_o(pend),
    .irq_o (irq_o)
  );

  always_comb begin
    case (reg_i)
      REG_DATA:   rdata_o = (rmw_i ? data_q : pin_s) & USED;
      REG_DIR:    rdata_o = dir_q;
      REG_SEL:    rdata_o = sel_q;
      REG_INMODE: rdata_o = inmode_q;
      REG_MASK:   rdata_o = mask_q;
      REG_EDGE:   rdata_o = {{(W-1){1'b0}}, fall_q};
      REG_PEND:   rdata_o = pend;
      default:    rdata_o = '0;
    endcase
  end

  assign eff_out = ((sel_q & periph_out_i) | (~sel_q & data_q)) & USED;
  assign eff_oe  = ((sel_q & periph_oe_i)  | (~sel_q & dir_q))  & USED;

  // snapshot tracks live drive until hold freezes it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_out_q <= '0;
      snap_oe_q  <= '0;
    end else if (!hold_i) begin
      snap_out_q <= eff_out;
      snap_oe_q  <= eff_oe;
    end
  end

  assign pad_out_o = hold_i ? snap_out_q : eff_out;
  assign pad_oe_o  = hold_i ? snap_oe_q  : eff_oe;
  assign pull_en_o = ~inmode_q & ~pad_oe_o & PULLABLE;

  // R8
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && $past(hold_i)) |-> ($stable(pad_oe_o) && $stable(pad_out_o)));
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic            bus_we_i,
  input  logic            bus_rmw_i,
  input  logic [PW-1:0]   bus_wdata_i,
  output logic [PW-1:0]   bus_rdata_o,
  input  logic            hold_i,
  input  logic [NPIN-1:0] pad_in_i,
  input  logic [NPIN-1:0] periph_out_i,
  input  logic [NPIN-1:0] periph_oe_i,
  output logic [NPIN-1:0] pad_out_o,
  output logic [NPIN-1:0] pad_oe_o,
  output logic [NPIN-1:0] pad_pull_en_o,
  output logic [NPORT-1:0] irq_o,
  output logic            wake_o
);
  localparam int NSLOT = 2 ** PSEL_W;

  logic [PSEL_W-1:0] port_sel;
  reg_e              reg_sel;
  logic [PW-1:0]     rd_arr [NSLOT];

  assign port_sel = bus_addr_i[AW-1:RSEL_W];
  assign reg_sel  = reg_e'(bus_addr_i[RSEL_W-1:0]);

  for (genvar p = 0; p < NSLOT; p++) begin : g_port
    if (p < NPORT) begin : g_inst
      gpio_port #(
        .W       (PW),
        .USED    (used_mask(p)),
        .PULLABLE(pull_mask(p))
      ) i_port (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .we_i        (bus_we_i && port_sel == PSEL_W'(p)),
        .reg_i       (reg_sel),
        .wdata_i     (bus_wdata_i),
        .rmw_i       (bus_rmw_i),
        .rdata_o     (rd_arr[p]),
        .hold_i      (hold_i),
        .pin_i       (pad_in_i[p*PW +: PW]),
        .periph_out_i(periph_out_i[p*PW +: PW]),
        .periph_oe_i (periph_oe_i[p*PW +: PW]),
        .pad_out_o   (pad_out_o[p*PW +: PW]),
        .pad_oe_o    (pad_oe_o[p*PW +: PW]),
        .pull_en_o   (pad_pull_en_o[p*PW +: PW]),
        .irq_o       (irq_o[p])
      );
    end else begin : g_empty
      assign rd_arr[p] = '0;
    end
  end

  assign bus_rdata_o = rd_arr[port_sel];
  assign wake_o      = |irq_o;

  // R2
  always_comb begin
    if (rst_ni && port_sel == 2'd2)
      p2_upper_zero_chk: assert ((bus_rdata_o & ~used_mask(2)) == '0);
  end
endmodule

// File: tb/test_gpio_port_ctrl.sv
module test_gpio_port_ctrl;
  import gpio_pkg::*;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [AW-1:0]   bus_addr_i = '0;
  logic            bus_we_i = 1'b0;
  logic            bus_rmw_i = 1'b0;
  logic [PW-1:0]   bus_wdata_i = '0;
  logic [PW-1:0]   bus_rdata_o;
  logic            hold_i = 1'b0;
  logic [NPIN-1:0] pad_in_i = '0;
  logic [NPIN-1:0] periph_out_i = '0;
  logic [NPIN-1:0] periph_oe_i = '0;
  logic [NPIN-1:0] pad_out_o, pad_oe_o, pad_pull_en_o;
  logic [NPORT-1:0] irq_o;
  logic            wake_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  gpio_port_ctrl i_gpio_port_ctrl (.*);

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int p, int r, logic [7:0] d);
    @(negedge clk_i);
    bus_addr_i = AW'((p << RSEL_W) | r);
    bus_wdata_i = d;
    bus_we_i = 1'b1;
    @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(int p, int r, bit rmw, output logic [7:0] d);
    bus_addr_i = AW'((p << RSEL_W) | r);
    bus_rmw_i = rmw;
    #1 d = bus_rdata_o;
    bus_rmw_i = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int p = 0; p < NPORT; p++) begin
      for (int r = 1; r <= 6; r++) begin
        rd(p, r, 0, d);
        chk("R1 reg reset", d, 0);
      end
    end
    chk("R1 oe reset", pad_oe_o, 0);
    chk("R1 pull reset", pad_pull_en_o, 24'h1FFCFF);
    chk("R1 irq reset", irq_o, 0);
  endtask

  task automatic t_port2();
    logic [7:0] d;
    wr(2, 1, 8'hFF);
    wr(2, 0, 8'hFF);
    rd(2, 1, 0, d);
    chk("R2 dir upper bits", d, 8'h1F);
    rd(2, 0, 1, d);
    chk("R2 latch upper bits", d, 8'h1F);
    chk("R2 pad oe", pad_oe_o[23:16], 8'h1F);
    chk("R2 pad out", pad_out_o[23:16], 8'h1F);
    wr(2, 1, 8'h00);
  endtask

  task automatic t_output();
    wr(0, 0, 8'h3C);
    wr(0, 1, 8'hFF);
    chk("R3 pad out", pad_out_o[7:0], 8'h3C);
    chk("R3 pad oe", pad_oe_o[7:0], 8'hFF);
  endtask

  task automatic t_read();
    logic [7:0] d;
    @(negedge clk_i);
    pad_in_i[15:8] = 8'h96;
    pad_in_i[7:0] = 8'hC3;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    rd(1, 0, 0, d);
    chk("R4 input pin read", d, 8'h96);
    rd(0, 0, 0, d);
    chk("R4 output pin reads level", d, 8'hC3);
  endtask

  task automatic t_rmw();
    logic [7:0] d;
    rd(0, 0, 1, d);
    chk("R5 rmw returns latch", d, 8'h3C);
  endtask

  task automatic t_periph();
    logic [7:0] d;
    periph_out_i[7:0] = 8'h05;
    periph_oe_i[7:0] = 8'h03;
    wr(0, 2, 8'h0F);
    chk("R6 periph out mux", pad_out_o[7:0], 8'h35);
    chk("R6 periph oe mux", pad_oe_o[7:0], 8'hF3);
    rd(0, 0, 1, d);
    chk("R6 latch kept", d, 8'h3C);
    wr(0, 2, 8'h00);
    chk("R6 latch restored", pad_out_o[7:0], 8'h3C);
  endtask

  task automatic t_pull();
    wr(1, 3, 8'h0F);
    chk("R7 inmode off", pad_pull_en_o[15:8], 8'hF0);
    wr(1, 3, 8'h00);
    chk("R7 no pull on p1 bits 0 1", pad_pull_en_o[15:8], 8'hFC);
    chk("R7 driven pins no pull", pad_pull_en_o[7:0], 8'h00);
  endtask

  task automatic t_hold();
    @(negedge clk_i);
    hold_i = 1'b1;
    wr(0, 0, 8'h55);
    wr(0, 1, 8'h00);
    chk("R8 out held", pad_out_o[7:0], 8'h3C);
    chk("R8 oe held", pad_oe_o[7:0], 8'hFF);
    @(negedge clk_i);
    hold_i = 1'b0;
    #1;
    chk("R8 out after release", pad_out_o[7:0], 8'h55);
    chk("R8 oe after release", pad_oe_o[7:0], 8'h00);
  endtask

  task automatic t_edge();
    logic [7:0] d;
    wr(1, 6, 8'hFF);
    wr(1, 4, 8'h01);
    pad_in_i[15:8] = 8'h97;
    settle();
    rd(1, 6, 0, d);
    chk("R9 rising sets", d, 8'h01);
    chk("R11 irq on", irq_o[1], 1);
    chk("R11 wake", wake_o, 1);
    wr(1, 4, 8'h00);
    chk("R11 masked", irq_o[1], 0);
    wr(1, 5, 8'h01);
    wr(1, 6, 8'hFF);
    rd(1, 6, 0, d);
    chk("R10 clear", d, 8'h00);
    pad_in_i[15:8] = 8'h96;
    settle();
    rd(1, 6, 0, d);
    chk("R9 falling sets", d, 8'h01);
    wr(1, 6, 8'hFE);
    rd(1, 6, 0, d);
    chk("R10 write 0 keeps", d, 8'h01);
    wr(1, 6, 8'h01);
    pad_in_i[15:8] = 8'h97;
    settle();
    rd(1, 6, 0, d);
    chk("R9 wrong polarity ignored", d, 8'h00);
  endtask

  task automatic t_race();
    logic [7:0] d;
    wr(1, 5, 8'h00);
    @(negedge clk_i);
    pad_in_i[15:8] = 8'h96;
    settle();
    @(negedge clk_i);
    pad_in_i[15:8] = 8'h97;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    bus_addr_i = AW'((1 << RSEL_W) | 6);
    bus_wdata_i = 8'h01;
    bus_we_i = 1'b1;
    @(negedge clk_i);
    bus_we_i = 1'b0;
    rd(1, 6, 0, d);
    chk("R10 set wins over clear", d, 8'h01);
    wr(1, 6, 8'h01);
    rd(1, 6, 0, d);
    chk("R10 lone clear", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_port2();
    t_output();
    t_read();
    t_rmw();
    t_periph();
    t_pull();
    t_hold();
    t_edge();
    t_race();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule